// File: doc/BRIEF.md
# Hysteresis Threshold Interrupt Comparator

This block watches a stream of conversion results and compares each one with a programmable upper and lower limit. A result must sit beyond a limit for a programmed number of consecutive conversions before anything changes. When the upper limit qualifies, the interrupt line goes to its active level and the "above" flag is raised. When the lower limit qualifies, the interrupt goes inactive and the "below" flag is raised. Between those two events the outputs hold their value, so the line acts like a switch with hysteresis.

A separate ready bit reports that a new result has arrived. Any completed conversion sets it. A configuration read clears it, and so does a configuration write that selects an active (non-shutdown) mode. None of these configuration accesses touches the comparison state. When the two top bits of the lower limit are both 1, the limits select a different reporting scheme that is handled elsewhere. In that case the comparator holds its flags and restarts its counts.

Top module: `thresh_hyst_irq`

## Requirements
- R1: When `res_word > lim_hi` (unsigned) on N consecutive valid results, the next cycle shows `flag_above`=1, `flag_below`=0 and the interrupt at its active level.
- R2: When `res_word < lim_lo` (unsigned) on N consecutive valid results, the next cycle shows `flag_below`=1, `flag_above`=0 and the interrupt at its inactive level.
- R3: `fault_sel` values 0, 1, 2 and 3 select N = 1, 2, 4 and 8. After N-1 qualifying results the flags and interrupt are unchanged. A valid result that does not qualify restarts that direction's run. A result equal to a limit does not qualify.
- R4: Configuration reads and writes never change `flag_above`, `flag_below` or `irq`, and they do not restart a run in progress.
- R5: Every cycle with `res_valid`=1 makes `conv_ready`=1 in the next cycle, whether or not a limit qualified.
- R6: If there is no valid result in the same cycle, `conv_ready` is cleared in the next cycle by `cfg_rd`=1, or by `cfg_wr`=1 with `cfg_wr_mode` not equal to 2'b00. `cfg_wr` with `cfg_wr_mode`=2'b00 leaves it unchanged.
- R7: With `irq_pol`=1 the active interrupt level is logic 1; with `irq_pol`=0 it is logic 0.
- R8: While `lim_lo[W-1:W-2]` = 2'b11, valid results leave both flags and the interrupt unchanged and restart both runs.
- R9: After reset both flags and `conv_ready` are 0 and the interrupt is inactive.
- R10: `flag_above` and `flag_below` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Strobe marking a completed conversion |
| res_word | input | W | Conversion result |
| lim_hi | input | W | Upper limit |
| lim_lo | input | W | Lower limit; top two bits both set selects bypass |
| fault_sel | input | FAULT_W | Consecutive-event count selector (N = 2^fault_sel) |
| irq_pol | input | 1 | 1: interrupt active high, 0: active low |
| cfg_rd | input | 1 | Configuration register read strobe |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wr_mode | input | 2 | Mode value written; 2'b00 is shutdown |
| irq | output | 1 | Interrupt line |
| flag_above | output | 1 | Last qualified crossing was above the upper limit |
| flag_below | output | 1 | Last qualified crossing was below the lower limit |
| conv_ready | output | 1 | Result available since last clearing access |

## Verification
The stimulus uses runs of results beyond each limit that are exactly N-1 and exactly N long for every count setting. These show whether the qualifier counts exactly, and whether a miss or a configuration access in the middle of a run wrongly restarts it. Results equal to each limit separate strict from inclusive comparison. Reads, shutdown writes and active-mode writes, alone and in the same cycle as a result, separate the three ready-bit cases and the priority between setting and clearing. Polarity flips and a lower limit with both top bits set cover the output level and the bypass.

// File: rtl/thresh_hyst_irq.sv
module thresh_hyst_irq #(
  parameter int W       = 16,
  parameter int FAULT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  logic [W-1:0]       res_word,
  input  logic [W-1:0]       lim_hi,
  input  logic [W-1:0]       lim_lo,
  input  logic [FAULT_W-1:0] fault_sel,
  input  logic               irq_pol,
  input  logic               cfg_rd,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_wr_mode,
  output logic               irq,
  output logic               flag_above,
  output logic               flag_below,
  output logic               conv_ready
);
  localparam int CNT_W = 2 ** FAULT_W;

  logic [CNT_W-1:0] run_hi, run_lo, need, run_hi_nxt, run_lo_nxt;
  logic above, below, bypass, hit_hi, hit_lo, ready_clr;

  assign need   = CNT_W'(1) << fault_sel;
  assign bypass = lim_lo[W-1] & lim_lo[W-2];
  assign above  = res_word > lim_hi;
  assign below  = res_word < lim_lo;

  assign run_hi_nxt = !above ? '0 : (run_hi >= need) ? run_hi : run_hi + CNT_W'(1);
  assign run_lo_nxt = !below ? '0 : (run_lo >= need) ? run_lo : run_lo + CNT_W'(1);

  assign hit_hi = !bypass && above && (run_hi_nxt >= need);
  assign hit_lo = !bypass && below && (run_lo_nxt >= need) && !hit_hi;

  assign ready_clr = cfg_rd || (cfg_wr && cfg_wr_mode != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_hi     <= '0;
      run_lo     <= '0;
      flag_above <= 1'b0;
      flag_below <= 1'b0;
    end else if (res_valid) begin
      run_hi <= bypass ? '0 : run_hi_nxt;
      run_lo <= bypass ? '0 : run_lo_nxt;
      if (hit_hi) begin
        flag_above <= 1'b1;
        flag_below <= 1'b0;
      end else if (hit_lo) begin
        flag_above <= 1'b0;
        flag_below <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         conv_ready <= 1'b0;
    else if (res_valid) conv_ready <= 1'b1;
    else if (ready_clr) conv_ready <= 1'b0;
  end

  assign irq = irq_pol ? flag_above : !flag_above;
endmodule

module thresh_hyst_irq_chk #(
  parameter int W       = 16,
  parameter int FAULT_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               res_valid,
  input logic [W-1:0]       res_word,
  input logic [W-1:0]       lim_hi,
  input logic [W-1:0]       lim_lo,
  input logic [FAULT_W-1:0] fault_sel,
  input logic               irq_pol,
  input logic               cfg_rd,
  input logic               cfg_wr,
  input logic [1:0]         cfg_wr_mode,
  input logic               irq,
  input logic               flag_above,
  input logic               flag_below,
  input logic               conv_ready
);
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_above && flag_below));

  assert_cfg_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rd || cfg_wr) && !res_valid) |=> ($stable(flag_above) && $stable(flag_below)));

  assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> conv_ready);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !res_valid) |=> !conv_ready);

  assert_shutdown_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wr_mode == 2'b00 && !cfg_rd && !res_valid) |=> $stable(conv_ready));

  assert_bypass_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_lo[W-1] && lim_lo[W-2]) |=> ($stable(flag_above) && $stable(flag_below)));

  assert_rise_needs_above_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_above) |-> $past(res_valid && (res_word > lim_hi)));

  assert_rise_needs_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_below) |-> $past(res_valid && (res_word < lim_lo)));
endmodule

bind thresh_hyst_irq thresh_hyst_irq_chk #(.W(W), .FAULT_W(FAULT_W)) u_chk (.*);

// File: tb/test_thresh_hyst_irq.sv
module test_thresh_hyst_irq;
  localparam int W = 16;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [W-1:0] res_word = '0;
  logic [W-1:0] lim_hi = 16'd1000;
  logic [W-1:0] lim_lo = 16'd100;
  logic [1:0] fault_sel = 2'd0;
  logic irq_pol = 1'b1;
  logic cfg_rd = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_wr_mode = 2'd0;
  logic irq, flag_above, flag_below, conv_ready;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thresh_hyst_irq #(.W(W), .FAULT_W(2)) i_thresh_hyst_irq (.*);

  // {valid, result, fault_sel, rd, wr, mode, exp_above, exp_below, exp_ready}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 16'd2000, 2'd1, 1'b0, 1'b0, 2'd0, 3'b001}, // R3 N-1 of 2
    {1'b0, 16'd0,    2'd1, 1'b1, 1'b0, 2'd0, 3'b000}, // R6 read clears
    {1'b1, 16'd2000, 2'd1, 1'b0, 1'b0, 2'd0, 3'b101}, // R1 N of 2
    {1'b1, 16'd500,  2'd1, 1'b0, 1'b0, 2'd0, 3'b101}, // R5 no qualify
    {1'b0, 16'd0,    2'd1, 1'b0, 1'b1, 2'd0, 3'b101}, // R6 shutdown write keeps
    {1'b0, 16'd0,    2'd1, 1'b0, 1'b1, 2'd2, 3'b100}, // R6 active write clears
    {1'b1, 16'd50,   2'd2, 1'b0, 1'b0, 2'd0, 3'b101}, // R3 1 of 4
    {1'b1, 16'd50,   2'd2, 1'b0, 1'b0, 2'd0, 3'b101},
    {1'b1, 16'd50,   2'd2, 1'b0, 1'b0, 2'd0, 3'b101}, // R3 N-1 of 4
    {1'b0, 16'd0,    2'd2, 1'b1, 1'b0, 2'd0, 3'b100}, // R4 read mid-run
    {1'b1, 16'd50,   2'd2, 1'b0, 1'b0, 2'd0, 3'b011}, // R2 N of 4
    {1'b1, 16'd1000, 2'd0, 1'b0, 1'b0, 2'd0, 3'b011}, // R3 equal high
    {1'b1, 16'd1001, 2'd0, 1'b0, 1'b0, 2'd0, 3'b101}, // R1 N of 1
    {1'b1, 16'd100,  2'd0, 1'b0, 1'b0, 2'd0, 3'b101}, // R3 equal low
    {1'b1, 16'd99,   2'd0, 1'b0, 1'b0, 2'd0, 3'b011}, // R2 N of 1
    {1'b0, 16'd0,    2'd0, 1'b1, 1'b0, 2'd0, 3'b010}, // R6 read clears
    {1'b1, 16'd99,   2'd0, 1'b1, 1'b0, 2'd0, 3'b011}  // R6 valid beats read
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] r, input logic rd,
                      input logic wr, input logic [1:0] md);
    res_valid = v; res_word = r; cfg_rd = rd; cfg_wr = wr; cfg_wr_mode = md;
    @(negedge clk);
    res_valid = 1'b0; cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_wr_mode = 2'd0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R9 above", flag_above, 1'b0);
    check("R9 below", flag_below, 1'b0);
    check("R9 ready", conv_ready, 1'b0);
    check("R9 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      fault_sel = VEC[i][8:7];
      step(VEC[i][25], VEC[i][24:9], VEC[i][6], VEC[i][5], VEC[i][4:3]);
      check($sformatf("R1 R2 R3 R4 above vec %0d", i), flag_above, VEC[i][2]);
      check($sformatf("R1 R2 R3 R4 below vec %0d", i), flag_below, VEC[i][1]);
      check($sformatf("R5 R6 ready vec %0d", i), conv_ready, VEC[i][0]);
      check($sformatf("R7 irq vec %0d", i), irq, VEC[i][2]);
      check($sformatf("R10 exclusive vec %0d", i), flag_above & flag_below, 1'b0);
    end

    // R3: eight-event setting, N-1 then N, with a write inside the run (R4)
    fault_sel = 2'd3;
    for (int k = 0; k < 7; k++) begin
      step(1'b1, 16'd3000, 1'b0, 1'b0, 2'd0);
      if (k == 3) step(1'b0, 16'd0, 1'b0, 1'b1, 2'd1);
    end
    check("R3 N-1 of 8 above", flag_above, 1'b0);
    check("R3 N-1 of 8 below", flag_below, 1'b1);
    step(1'b1, 16'd3000, 1'b0, 1'b0, 2'd0);
    check("R1 N of 8 above", flag_above, 1'b1);
    check("R1 N of 8 below", flag_below, 1'b0);

    // R3: a miss restarts the run
    fault_sel = 2'd1;
    step(1'b1, 16'd10, 1'b0, 1'b0, 2'd0);
    step(1'b1, 16'd500, 1'b0, 1'b0, 2'd0);
    step(1'b1, 16'd10, 1'b0, 1'b0, 2'd0);
    check("R3 restart after miss", flag_below, 1'b0);
    step(1'b1, 16'd10, 1'b0, 1'b0, 2'd0);
    check("R2 after restart", flag_below, 1'b1);

    // R7: polarity
    irq_pol = 1'b0;
    #1 check("R7 inactive low-pol", irq, 1'b1);
    fault_sel = 2'd0;
    step(1'b1, 16'd5000, 1'b0, 1'b0, 2'd0);
    check("R7 active low-pol", irq, 1'b0);
    irq_pol = 1'b1;

    // R8: bypass when both top bits of lower limit set
    lim_lo = 16'hC000;
    step(1'b1, 16'd10, 1'b0, 1'b0, 2'd0);
    check("R8 above held", flag_above, 1'b1);
    check("R8 below held", flag_below, 1'b0);
    check("R5 ready in bypass", conv_ready, 1'b1);
    lim_lo = 16'h8000;
    step(1'b1, 16'd10, 1'b0, 1'b0, 2'd0);
    check("R2 one top bit only", flag_below, 1'b1);

    // R9: reset mid-run
    rst_n = 1'b0;
    #1;
    check("R9 above after reset", flag_above, 1'b0);
    check("R9 below after reset", flag_below, 1'b0);
    check("R9 ready after reset", conv_ready, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule